// File: doc/BRIEF.md
# High-Speed Burst Framer with Trail

This block frames one high-speed burst on a serial data lane. While the lane rests in Stop, it accepts a first byte from a valid/ready/last byte stream. It then drives the two low-power lines through the request states and switches to differential driving. The differential phase has four parts in order: a zero preamble, a fixed sync byte, the payload bytes and a trail state. Each bit goes out on one clock cycle, least significant bit first. After the trail, the block releases the differential driver and returns the lines to Stop.

The durations of the request states, the zero preamble and the trail are programmable in clock cycles. So is the minimum time the lane must rest in Stop before the next burst. The payload is streamed without gaps. A missing byte at a handover slot ends the burst after the byte being sent, so the lane never stalls in the middle of differential driving.

Top module: `hs_burst_framer`

## Requirements
- R1: When a byte is accepted in Stop, the next cycle starts the request. `lp_o` is `01` for max(`t_lp01_i`,1) cycles and then `00` for max(`t_lp00_i`,1) cycles. `lp_o[1]` is the positive line and `lp_o[0]` is the negative line.
- R2: After the request, `hs_en_o` rises with `hs_o`=0. This zero preamble lasts max(`t_zero_i`,1) cycles.
- R3: The sync byte 8'b0001_1101 follows the preamble, least significant bit first, one bit per cycle. On the line this is the bit sequence 1,0,1,1,1,0,0,0.
- R4: Payload bytes follow the sync byte back to back. Each byte is sent bit 0 first and bit 7 last, one bit per cycle.
- R5: Whenever `hs_en_o` is high, `lp_o` is `00`.
- R6: After the last payload bit, `hs_o` holds the inverse of that bit for max(`t_trail_i`,1) cycles. In the cycle after that, `hs_en_o` is low and `lp_o` is `11`.
- R7: `ready_o` is high in two cases: in Stop once the guard interval has passed, and during bit 7 of a payload byte that was not marked last. A byte is taken when `valid_i` and `ready_o` are both high. The byte marked last ends the payload.
- R8: If `valid_i` is low during a mid-burst handover slot, no byte is taken and the trail follows the byte currently being sent.
- R9: After Stop is entered, whether through reset or at the end of a trail, `ready_o` stays low for the first `t_stop_i` cycles. The earliest possible request therefore begins after `t_stop_i`+1 cycles in Stop.
- R10: During and after reset, `lp_o` is `11`, `hs_en_o` is 0 and `ready_o` is 0 unless `t_stop_i` is 0. Whenever `hs_en_o` is low, `hs_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| t_lp01_i | input | CNT_W | Request state 01 length in cycles |
| t_lp00_i | input | CNT_W | Request state 00 length in cycles |
| t_zero_i | input | CNT_W | Zero preamble length in cycles |
| t_trail_i | input | CNT_W | Trail length in cycles |
| t_stop_i | input | CNT_W | Minimum Stop rest before the next burst |
| data_i | input | 8 | Payload byte |
| valid_i | input | 1 | Byte valid |
| last_i | input | 1 | Byte is the last of the burst |
| ready_o | output | 1 | Byte taken at this edge if valid |
| lp_o | output | 2 | Low-power line states, {positive, negative} |
| hs_o | output | 1 | Serial differential bit |
| hs_en_o | output | 1 | Differential driver enable |

## Verification
The hardest case to reach is the mid-burst handover slot. There, a single cycle of `valid_i` decides whether the burst continues or goes straight into the trail. The bench's vector table holds a per-vector gap index that drops `valid_i` exactly when that byte would be offered, including a gap at the very first handover. The bench then compares the whole line waveform against a cycle-by-cycle model, up to the return to Stop. The guard interval is checked across back-to-back bursts and after a reset taken in the middle of a burst.

// File: rtl/hsbf_pkg.sv
package hsbf_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned IDX_W  = $clog2(BYTE_W);
  localparam logic [BYTE_W-1:0] SYNC_BYTE = 8'b0001_1101;

  localparam logic [1:0] LP_STOP = 2'b11;
  localparam logic [1:0] LP_RQ   = 2'b01;
  localparam logic [1:0] LP_BR   = 2'b00;

  typedef enum logic [2:0] {
    ST_STOP,
    ST_REQ01,
    ST_REQ00,
    ST_ZERO,
    ST_SYNC,
    ST_DATA,
    ST_TRAIL
  } hsbf_state_e;
endpackage

// File: rtl/hsbf_timer.sv
// Phase length counter: a loaded length N lasts max(N,1) cycles.
module hsbf_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;

  assign expire_o = (cnt_q <= CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (load_i)       cnt_q <= len_i;
    else if (!expire_o)    cnt_q <= cnt_q - CNT_W'(1);
  end
endmodule

// File: rtl/hsbf_guard.sv
// Counts cycles spent in Stop, saturating.
module hsbf_guard #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             ok_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  logic [CNT_W-1:0] cnt_q;

  assign ok_o = (cnt_q >= limit_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clear_i)           cnt_q <= '0;
    else if (cnt_q != CNT_MAX)  cnt_q <= cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/hsbf_serializer.sv
module hsbf_serializer
  import hsbf_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              last_i,
  input  logic              shift_i,
  output logic              bit_o,
  output logic              msb_o,
  output logic              last_o
);
  localparam logic [IDX_W-1:0] IDX_TOP = IDX_W'(BYTE_W - 1);

  logic [BYTE_W-1:0] sh_q;
  logic [IDX_W-1:0]  idx_q;
  logic              last_q;

  assign bit_o  = sh_q[0];
  assign msb_o  = (idx_q == IDX_TOP);
  assign last_o = last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      idx_q  <= '0;
      last_q <= 1'b0;
    end else if (load_i) begin
      sh_q   <= byte_i;
      idx_q  <= '0;
      last_q <= last_i;
    end else if (shift_i) begin
      sh_q   <= {1'b0, sh_q[BYTE_W-1:1]};
      idx_q  <= idx_q + IDX_W'(1);
    end
  end
endmodule

// File: rtl/hs_burst_framer.sv
module hs_burst_framer
  import hsbf_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CNT_W-1:0]  t_lp01_i,
  input  logic [CNT_W-1:0]  t_lp00_i,
  input  logic [CNT_W-1:0]  t_zero_i,
  input  logic [CNT_W-1:0]  t_trail_i,
  input  logic [CNT_W-1:0]  t_stop_i,
  input  logic [BYTE_W-1:0] data_i,
  input  logic              valid_i,
  input  logic              last_i,
  output logic              ready_o,
  output logic [1:0]        lp_o,
  output logic              hs_o,
  output logic              hs_en_o
);
  hsbf_state_e       state_q, state_d;
  logic [BYTE_W-1:0] stage_q;
  logic              stage_last_q;
  logic              trail_bit_q;

  logic              tm_load, tm_expire;
  logic [CNT_W-1:0]  tm_len;
  logic              guard_ok;
  logic              ser_load, ser_shift, ser_bit, ser_msb, ser_last;
  logic [BYTE_W-1:0] ser_byte;
  logic              ser_byte_last;
  logic              take;

  hsbf_timer #(.CNT_W(CNT_W)) i_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (tm_load),
    .len_i    (tm_len),
    .expire_o (tm_expire)
  );

  hsbf_guard #(.CNT_W(CNT_W)) i_guard (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (state_q != ST_STOP),
    .limit_i (t_stop_i),
    .ok_o    (guard_ok)
  );

  hsbf_serializer i_ser (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (ser_load),
    .byte_i  (ser_byte),
    .last_i  (ser_byte_last),
    .shift_i (ser_shift),
    .bit_o   (ser_bit),
    .msb_o   (ser_msb),
    .last_o  (ser_last)
  );

  assign ready_o = ((state_q == ST_STOP) && guard_ok) ||
                   ((state_q == ST_DATA) && ser_msb && !ser_last);
  assign take    = ready_o && valid_i;

  always_comb begin
    state_d       = state_q;
    tm_load       = 1'b0;
    tm_len        = '0;
    ser_load      = 1'b0;
    ser_shift     = 1'b0;
    ser_byte      = data_i;
    ser_byte_last = last_i;
    unique case (state_q)
      ST_STOP: if (take) begin
        state_d = ST_REQ01;
        tm_load = 1'b1;
        tm_len  = t_lp01_i;
      end
      ST_REQ01: if (tm_expire) begin
        state_d = ST_REQ00;
        tm_load = 1'b1;
        tm_len  = t_lp00_i;
      end
      ST_REQ00: if (tm_expire) begin
        state_d = ST_ZERO;
        tm_load = 1'b1;
        tm_len  = t_zero_i;
      end
      ST_ZERO: if (tm_expire) begin
        state_d       = ST_SYNC;
        ser_load      = 1'b1;
        ser_byte      = SYNC_BYTE;
        ser_byte_last = 1'b0;
      end
      ST_SYNC: begin
        if (ser_msb) begin
          state_d       = ST_DATA;
          ser_load      = 1'b1;
          ser_byte      = stage_q;
          ser_byte_last = stage_last_q;
        end else begin
          ser_shift = 1'b1;
        end
      end
      ST_DATA: begin
        if (ser_msb) begin
          if (take) begin
            ser_load = 1'b1;
          end else begin
            state_d = ST_TRAIL;
            tm_load = 1'b1;
            tm_len  = t_trail_i;
          end
        end else begin
          ser_shift = 1'b1;
        end
      end
      ST_TRAIL: if (tm_expire) state_d = ST_STOP;
      default:  state_d = ST_STOP;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_STOP;
      stage_q      <= '0;
      stage_last_q <= 1'b0;
      trail_bit_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_STOP && take) begin
        stage_q      <= data_i;
        stage_last_q <= last_i;
      end
      if (state_q == ST_DATA && state_d == ST_TRAIL) trail_bit_q <= ~ser_bit;
    end
  end

  always_comb begin
    unique case (state_q)
      ST_STOP:  lp_o = LP_STOP;
      ST_REQ01: lp_o = LP_RQ;
      default:  lp_o = LP_BR;
    endcase
    hs_en_o = (state_q == ST_ZERO) || (state_q == ST_SYNC) ||
              (state_q == ST_DATA) || (state_q == ST_TRAIL);
    unique case (state_q)
      ST_SYNC, ST_DATA: hs_o = ser_bit;
      ST_TRAIL:         hs_o = trail_bit_q;
      default:          hs_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/hsbf_checks.sv
module hsbf_checks (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       ready_o,
  input logic [1:0] lp_o,
  input logic       hs_o,
  input logic       hs_en_o
);
  a_r5_lp00_while_hs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hs_en_o |-> lp_o == 2'b00);

  a_r10_hs_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hs_en_o |-> !hs_o);

  a_r1_rq_from_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lp_o == 2'b01 && $past(lp_o) != 2'b01) |-> $past(lp_o) == 2'b11);

  a_r2_hs_after_bridge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hs_en_o) |-> $past(lp_o) == 2'b00);

  a_r6_trail_to_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hs_en_o) |-> lp_o == 2'b11);

  a_r7_ready_phase: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (lp_o == 2'b11 || hs_en_o));
endmodule

bind hs_burst_framer hsbf_checks i_checks (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .ready_o (ready_o),
  .lp_o    (lp_o),
  .hs_o    (hs_o),
  .hs_en_o (hs_en_o)
);

// File: tb/test_hs_burst_framer.sv
module test_hs_burst_framer;
  localparam time CLK_PERIOD = 10ns;
  localparam int  NV = 6;
  localparam int V_T01 [NV] = '{1, 3, 0, 2, 1, 4};
  localparam int V_T00 [NV] = '{1, 2, 0, 3, 2, 1};
  localparam int V_TZ  [NV] = '{1, 4, 0, 2, 3, 2};
  localparam int V_TTR [NV] = '{1, 5, 0, 3, 2, 6};
  localparam int V_TST [NV] = '{0, 2, 1, 4, 3, 0};
  localparam int V_NB  [NV] = '{1, 3, 2, 4, 5, 2};
  localparam int V_SEED[NV] = '{8'hA5, 8'h3C, 8'h80, 8'h01, 8'hFF, 8'h7E};
  localparam int V_GAP [NV] = '{0, 0, 0, 2, 0, 1};
  localparam logic [7:0] SYNC = 8'b0001_1101;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] t_lp01, t_lp00, t_zero, t_trail, t_stop;
  logic [7:0] data;
  logic       valid = 1'b0, last = 1'b0;
  logic       ready, hs, hs_en;
  logic [1:0] lp;
  int         n_chk = 0, n_fail = 0;
  bit         done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hs_burst_framer i_hs_burst_framer (
    .clk_i(clk), .rst_ni(rst_n),
    .t_lp01_i(t_lp01), .t_lp00_i(t_lp00), .t_zero_i(t_zero),
    .t_trail_i(t_trail), .t_stop_i(t_stop),
    .data_i(data), .valid_i(valid), .last_i(last),
    .ready_o(ready), .lp_o(lp), .hs_o(hs), .hs_en_o(hs_en)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] byte_of(input int seed, input int i);
    return 8'(seed + 29 * i);
  endfunction

  function automatic int atl1(input int v);
    return (v < 1) ? 1 : v;
  endfunction

  // Called at a negedge in Stop cycle 0; returns at the negedge of the next Stop cycle 0.
  task automatic run_burst(input int t01, t00, tz, ttr, tst, nb, seed, gap, input string tag);
    int  a, b, z, t, sent, total, idx, stopc;
    bit  hsk;
    logic [3:0] exp_v;
    logic [7:0] lb;
    t_lp01 = 8'(t01); t_lp00 = 8'(t00); t_zero = 8'(tz);
    t_trail = 8'(ttr); t_stop = 8'(tst);
    a = atl1(t01); b = atl1(t00); z = atl1(tz); t = atl1(ttr);
    sent  = (gap > 0) ? gap : nb;
    total = a + b + z + 8 + 8 * sent + t;
    lb    = byte_of(seed, sent - 1);
    stopc = 0;
    forever begin
      data = byte_of(seed, 0); last = (nb == 1); valid = 1'b1;
      #1;
      check({"R9 guard ready ", tag}, ready, stopc >= tst);
      check({"R10 stop lines ", tag}, {lp, hs_en, hs}, 4'b1100);
      hsk = ready && valid;
      @(posedge clk);
      if (hsk) break;
      @(negedge clk);
      stopc++;
    end
    check({"R9 guard length ", tag}, stopc, tst);
    idx = 1;
    for (int k = 0; k <= total; k++) begin
      @(negedge clk);
      if (k < a)                     exp_v = {2'b01, 1'b0, 1'b0};
      else if (k < a + b)            exp_v = {2'b00, 1'b0, 1'b0};
      else if (k < a + b + z)        exp_v = {2'b00, 1'b1, 1'b0};
      else if (k < a + b + z + 8)    exp_v = {2'b00, 1'b1, SYNC[k - a - b - z]};
      else if (k < total - t) begin
        int p = k - a - b - z - 8;
        logic [7:0] by = byte_of(seed, p / 8);
        exp_v = {2'b00, 1'b1, by[p % 8]};
      end
      else if (k < total)            exp_v = {2'b00, 1'b1, ~lb[7]};
      else                           exp_v = {2'b11, 1'b0, 1'b0};
      if (k < a + b)                 check({"R1 request ", tag}, {lp, hs_en, hs}, exp_v);
      else if (k < a + b + z)        check({"R2 preamble ", tag}, {lp, hs_en, hs}, exp_v);
      else if (k < a + b + z + 8)    check({"R3 sync ", tag}, {lp, hs_en, hs}, exp_v);
      else if (k < total - t)        check({"R4 R5 payload ", tag}, {lp, hs_en, hs}, exp_v);
      else                           check({"R6 trail ", tag}, {lp, hs_en, hs}, exp_v);
      if (k == total) break;
      valid = (idx < nb) && !(gap > 0 && idx >= gap);
      data  = byte_of(seed, idx);
      last  = (idx == nb - 1);
      #1;
      hsk = ready && valid;
      @(posedge clk);
      if (hsk) idx++;
    end
    if (gap > 0) check({"R8 underrun bytes taken ", tag}, idx, sent);
    else         check({"R7 bytes taken ", tag}, idx, nb);
    valid = 1'b0;
  endtask

  initial begin
    t_lp01 = 8'd1; t_lp00 = 8'd1; t_zero = 8'd1; t_trail = 8'd1; t_stop = 8'd2;
    data = 8'h00;
    #(CLK_PERIOD * 3);
    check("R10 reset lines", {lp, hs_en, hs}, 4'b1100);
    check("R10 reset ready", ready, 0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int v = 0; v < NV; v++)
      run_burst(V_T01[v], V_T00[v], V_TZ[v], V_TTR[v], V_TST[v], V_NB[v],
                V_SEED[v], V_GAP[v], $sformatf("vec%0d", v));

    // Reset taken mid-burst, then guard after reset.
    t_stop = 8'd3; t_lp01 = 8'd1; t_lp00 = 8'd1; t_zero = 8'd1;
    data = 8'hC3; last = 1'b0; valid = 1'b1;
    repeat (12) @(negedge clk);
    valid = 1'b0;
    check("R5 mid-burst driving", {lp, hs_en}, 3'b001);
    rst_n = 1'b0;
    #1;
    check("R10 async reset lines", {lp, hs_en, hs}, 4'b1100);
    check("R10 async reset ready", ready, 0);
    @(negedge clk);
    rst_n = 1'b1;
    run_burst(2, 1, 2, 2, 3, 2, 8'h5A, 0, "post-reset");
    run_burst(1, 1, 1, 4, 5, 1, 8'h0F, 0, "single");
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule